// File: doc/BRIEF.md
# Multi-Channel Inter-Processor Mailbox

This block lets several processor cores signal one another through a set of independent message channels on a shared APB-style register bus. Every channel holds a 32-bit command word and a small destination mask. Only bit-set and bit-clear writes can change the command word. A sender checks that the channel is idle and selects the target core with the mask. It then ORs its message into the word. While the word is non-zero, the interrupt line of each core chosen by the mask stays high.

A receiver reads the command word and writes the same value back to the clear register. This empties the channel and drops the interrupt. A summary register holds one busy bit per channel, so a sender can poll all channels in a single read.

Each channel owns a 16-byte window, and channel n starts at byte offset n*0x10. The summary register sits at offset 0x100. Any address whose two low bits are not zero is unmapped.

Top module: `ipc_mailbox`

## Requirements
- R1: After the active-low reset, every command word and every mask reads as zero, the summary reads zero and every core interrupt is low.
- R2: A write to channel offset 0x4 ORs the write data into that channel's command word. The word reads back at channel offset 0xC.
- R3: A write to channel offset 0x8 clears the command bits that are set in the write data. Writing zero there leaves the word unchanged.
- R4: Channel offset 0x0 holds a 4-bit destination mask, with bit k selecting core k. Write data bits above bit 3 are dropped, and a read returns the mask zero-extended.
- R5: In the register at offset 0x100, bit n is 1 exactly when channel n's command word is non-zero. Bits 31:4 read as zero, and writes to this register have no effect.
- R6: Core interrupt k is a level that is high exactly when some channel has a non-zero command word and bit k set in its mask.
- R7: Reads of channel offsets 0x4 and 0x8 return the command word. Reads of any unmapped address return zero, including channel windows 4 and above, offsets above 0x100 and addresses that are not word-aligned.
- R8: A write to one channel leaves the registers of every other channel unchanged.
- R9: Registers change only in the access phase of a write, when psel, penable and pwrite are all high. A setup phase alone has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Selects the block for a transfer |
| penable | input | 1 | Marks the access phase of a transfer |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | 12 | Byte address inside the block |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during a read |
| coreIrq | output | 4 | Level interrupt, one per core |

## Verification
The command word is driven with set patterns whose bits overlap, to show that bits accumulate by OR and are not overwritten. It is then driven with clear patterns of all-zero, partial and all-ones values, which separate a true bit-clear from a plain overwrite or a full reset of the word. The masks are set to single-core and multi-core patterns on two channels at the same time. This exposes mixing of channels and cores in the interrupt OR. Reads at the summary register, at unused windows, at misaligned addresses and after a setup-only phase show decode leaks that a main-path test would not reveal.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MBX_NUM_CH    = 4;
  localparam int MBX_NUM_CORES = 4;
  localparam int MBX_DATA_W    = 32;
  localparam int MBX_ADDR_W    = 12;
  localparam int MBX_CH_W      = $clog2(MBX_NUM_CH);
  localparam int MBX_SUM_OFS   = 'h100;

  typedef enum logic [1:0] {RD_NONE, RD_MASK, RD_CMD, RD_SUM} rdKind_e;

  // strobes from decode to the register datapath
  typedef struct packed {
    logic [MBX_NUM_CH-1:0] maskWr;
    logic [MBX_NUM_CH-1:0] setWr;
    logic [MBX_NUM_CH-1:0] clrWr;
    rdKind_e               rdKind;
    logic [MBX_CH_W-1:0]   rdCh;
  } mbxStrobe_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int NUM_CH  = MBX_NUM_CH,
  parameter int ADDR_W  = MBX_ADDR_W,
  parameter int SUM_OFS = MBX_SUM_OFS
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output mbxStrobe_t        strobe
);
  localparam int WIN_W = ADDR_W - 4;

  logic [WIN_W-1:0] winIdx;
  logic [1:0]       regSel;
  logic             aligned;
  logic             inWin;
  logic             isSum;
  logic             wrEn;
  logic             rdEn;

  always_comb begin
    winIdx  = paddr[ADDR_W-1:4];
    regSel  = paddr[3:2];
    aligned = (paddr[1:0] == 2'b00);
    inWin   = aligned && (winIdx < WIN_W'(NUM_CH));
    isSum   = aligned && (paddr[ADDR_W-1:2] == (ADDR_W-2)'(SUM_OFS >> 2));
    wrEn    = psel && penable && pwrite;
    rdEn    = psel && !pwrite;
  end

  always_comb begin
    strobe = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (wrEn && inWin && winIdx == WIN_W'(c)) begin
        strobe.maskWr[c] = (regSel == 2'd0);
        strobe.setWr[c]  = (regSel == 2'd1);
        strobe.clrWr[c]  = (regSel == 2'd2);
      end
    end
    strobe.rdCh   = winIdx[MBX_CH_W-1:0];
    strobe.rdKind = RD_NONE;
    if (rdEn && inWin) begin
      strobe.rdKind = (regSel == 2'd0) ? RD_MASK : RD_CMD;
    end else if (rdEn && isSum) begin
      strobe.rdKind = RD_SUM;
    end
  end
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int NUM_CH    = MBX_NUM_CH,
  parameter int NUM_CORES = MBX_NUM_CORES,
  parameter int DATA_W    = MBX_DATA_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  mbxStrobe_t                    strobe,
  input  logic [DATA_W-1:0]             wrData,
  output logic [DATA_W-1:0]             rdData,
  output logic [NUM_CH-1:0][DATA_W-1:0] cmdWords,
  output logic [NUM_CORES-1:0]          coreIrq
);
  logic [NUM_CH-1:0][NUM_CORES-1:0] maskRegs;
  logic [NUM_CH-1:0]                busy;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [DATA_W-1:0] setBits;
    logic [DATA_W-1:0] clrBits;
    assign setBits = strobe.setWr[c] ? wrData : '0;
    assign clrBits = strobe.clrWr[c] ? wrData : '0;

    // clear lands after set when both reach one channel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmdWords[c] <= '0;
      end else if (strobe.setWr[c] || strobe.clrWr[c]) begin
        cmdWords[c] <= (cmdWords[c] | setBits) & ~clrBits;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskRegs[c] <= '0;
      end else if (strobe.maskWr[c]) begin
        maskRegs[c] <= wrData[NUM_CORES-1:0];
      end
    end

    assign busy[c] = |cmdWords[c];
  end

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    logic [NUM_CH-1:0] hits;
    always_comb begin
      for (int c = 0; c < NUM_CH; c++) begin
        hits[c] = busy[c] && maskRegs[c][k];
      end
    end
    assign coreIrq[k] = |hits;
  end

  always_comb begin
    unique case (strobe.rdKind)
      RD_MASK: rdData = DATA_W'(maskRegs[strobe.rdCh]);
      RD_CMD:  rdData = cmdWords[strobe.rdCh];
      RD_SUM:  rdData = DATA_W'(busy);
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int NUM_CH    = MBX_NUM_CH,
  parameter int NUM_CORES = MBX_NUM_CORES,
  parameter int DATA_W    = MBX_DATA_W,
  parameter int ADDR_W    = MBX_ADDR_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [DATA_W-1:0]    pwdata,
  output logic [DATA_W-1:0]    prdata,
  output logic [NUM_CORES-1:0] coreIrq
);
  mbxStrobe_t                    strobe;
  logic [NUM_CH-1:0][DATA_W-1:0] cmdWords;

  mbx_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SUM_OFS(MBX_SUM_OFS)) u_ctrl (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .strobe  (strobe)
  );

  mbx_datapath #(.NUM_CH(NUM_CH), .NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (pwdata),
    .rdData   (prdata),
    .cmdWords (cmdWords),
    .coreIrq  (coreIrq)
  );
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int NUM_CH    = 4,
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          psel,
  input logic                          penable,
  input logic                          pwrite,
  input logic [ADDR_W-1:0]             paddr,
  input logic [DATA_W-1:0]             pwdata,
  input logic [DATA_W-1:0]             prdata,
  input logic [NUM_CORES-1:0]          coreIrq,
  input logic [NUM_CH-1:0][DATA_W-1:0] cmdWords
);
  logic wrAcc;
  assign wrAcc = psel && penable && pwrite;

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (cmdWords == '0 && coreIrq == '0));

  p_irq_needs_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (coreIrq != '0) |-> (cmdWords != '0));

  p_sum_upper_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (psel && !pwrite && paddr == ADDR_W'('h100)) |-> (prdata[DATA_W-1:NUM_CH] == '0));

  p_setup_inert_r9: assert property (@(posedge clk) disable iff (!rstN)
    (psel && !penable) |=> $stable(cmdWords));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    p_set_keeps_r2: assert property (@(posedge clk) disable iff (!rstN)
      (wrAcc && paddr == ADDR_W'(c*16 + 4))
        |=> ((cmdWords[c] & $past(pwdata)) == $past(pwdata)));

    p_clr_drops_r3: assert property (@(posedge clk) disable iff (!rstN)
      (wrAcc && paddr == ADDR_W'(c*16 + 8))
        |=> ((cmdWords[c] & $past(pwdata)) == '0));

    p_other_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
      !(wrAcc && paddr[ADDR_W-1:4] == (ADDR_W-4)'(c)) |=> $stable(cmdWords[c]));
  end
endmodule

bind ipc_mailbox mbx_checker #(
  .NUM_CH(NUM_CH), .NUM_CORES(NUM_CORES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .pwdata   (pwdata),
  .prdata   (prdata),
  .coreIrq  (coreIrq),
  .cmdWords (cmdWords)
);

// File: tb/sim_ipc_mailbox.sv
module sim_ipc_mailbox;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [3:0]  coreIrq;

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  ipc_mailbox u0 (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .coreIrq(coreIrq)
  );

  typedef struct packed {
    logic        isRd;
    logic [11:0] addr;
    logic [31:0] data;
    logic [3:0]  irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 28;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 12'h000, 32'h0000_0002, 4'h0, 4'd6}, // R6 mask alone raises nothing
    '{1'b0, 12'h004, 32'h0000_00F0, 4'h2, 4'd2}, // R2 set
    '{1'b1, 12'h00C, 32'h0000_00F0, 4'h2, 4'd2},
    '{1'b0, 12'h004, 32'h0F00_000F, 4'h2, 4'd2}, // R2 OR accumulate
    '{1'b1, 12'h00C, 32'h0F00_00FF, 4'h2, 4'd2},
    '{1'b1, 12'h004, 32'h0F00_00FF, 4'h2, 4'd7}, // R7 set offset read
    '{1'b1, 12'h008, 32'h0F00_00FF, 4'h2, 4'd7}, // R7 clear offset read
    '{1'b1, 12'h100, 32'h0000_0001, 4'h2, 4'd5}, // R5
    '{1'b0, 12'h018, 32'hFFFF_FFFF, 4'h2, 4'd8}, // R8 clear on ch1
    '{1'b1, 12'h01C, 32'h0000_0000, 4'h2, 4'd8},
    '{1'b1, 12'h00C, 32'h0F00_00FF, 4'h2, 4'd8},
    '{1'b0, 12'h008, 32'h0000_0000, 4'h2, 4'd3}, // R3 zero clear
    '{1'b1, 12'h00C, 32'h0F00_00FF, 4'h2, 4'd3},
    '{1'b0, 12'h008, 32'h0F00_00F0, 4'h2, 4'd3}, // R3 partial clear
    '{1'b1, 12'h00C, 32'h0000_000F, 4'h2, 4'd3},
    '{1'b0, 12'h030, 32'hFFFF_FFF9, 4'h2, 4'd4}, // R4 mask width
    '{1'b1, 12'h030, 32'h0000_0009, 4'h2, 4'd4},
    '{1'b0, 12'h034, 32'h0000_0001, 4'hB, 4'd6}, // R6 two channels
    '{1'b1, 12'h100, 32'h0000_0009, 4'hB, 4'd5},
    '{1'b0, 12'h100, 32'hFFFF_FFFF, 4'hB, 4'd5}, // R5 write ignored
    '{1'b1, 12'h100, 32'h0000_0009, 4'hB, 4'd5},
    '{1'b1, 12'h040, 32'h0000_0000, 4'hB, 4'd7}, // R7 unmapped window
    '{1'b1, 12'h104, 32'h0000_0000, 4'hB, 4'd7},
    '{1'b1, 12'h00E, 32'h0000_0000, 4'hB, 4'd7}, // R7 misaligned
    '{1'b0, 12'h008, 32'h0000_000F, 4'h9, 4'd6},
    '{1'b1, 12'h100, 32'h0000_0008, 4'h9, 4'd5},
    '{1'b0, 12'h038, 32'h0000_0001, 4'h0, 4'd6},
    '{1'b1, 12'h100, 32'h0000_0000, 4'h0, 4'd5}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apbRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 irq after reset", 32'(coreIrq), 32'h0);
    apbRead(12'h00C, rd); check("R1 cmd0 reset", rd, 32'h0);
    apbRead(12'h000, rd); check("R1 mask0 reset", rd, 32'h0);
    apbRead(12'h100, rd); check("R1 summary reset", rd, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isRd) begin
        apbRead(VECS[i].addr, rd);
        check($sformatf("R%0d vec%0d read", VECS[i].req, i), rd, VECS[i].data);
      end else begin
        apbWrite(VECS[i].addr, VECS[i].data);
      end
      check($sformatf("R%0d vec%0d irq", VECS[i].req, i), 32'(coreIrq), 32'(VECS[i].irq));
    end

    // R6 and R3: shutdown-style writes on channel 2
    apbWrite(12'h020, 32'h1);
    apbWrite(12'h024, 32'h8000_0000);
    check("R6 ch2 irq on", 32'(coreIrq), 32'h1);
    apbWrite(12'h020, 32'h0);
    check("R6 mask cleared drops irq", 32'(coreIrq), 32'h0);
    apbWrite(12'h028, 32'h0);
    apbRead(12'h02C, rd); check("R3 zero clear keeps word", rd, 32'h8000_0000);
    apbRead(12'h100, rd); check("R5 ch2 busy", rd, 32'h4);

    // R9 setup phase only
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h024; pwdata = 32'h1;
    @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
    apbRead(12'h02C, rd); check("R9 setup-only write inert", rd, 32'h8000_0000);

    // R1 reset during operation
    apbWrite(12'h020, 32'h4);
    check("R1 pre-reset irq", 32'(coreIrq), 32'h4);
    @(negedge clk); rstN = 1'b0;
    #1 check("R1 irq in reset", 32'(coreIrq), 32'h0);
    @(negedge clk); rstN = 1'b1;
    apbRead(12'h02C, rd); check("R1 cmd2 after reset", rd, 32'h0);
    apbRead(12'h020, rd); check("R1 mask2 after reset", rd, 32'h0);
    apbRead(12'h100, rd); check("R1 summary after reset", rd, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule